// File: doc/BRIEF.md
# SPI Controller with Status Flags

This block is a byte-wide SPI peripheral with a small CPU-facing register interface. It can act as bus master or as slave. In master mode a CPU write to the data register loads the byte straight into the shift register and starts a transfer. The block generates SCLK in SPI mode 0 and shifts data MSB first. In slave mode the same write only preloads the shifter. The external master then clocks the byte out while the slave-select input is held low. The byte received in either role appears in a receive buffer, which is read back from the same register address.

A read-only status register holds three sticky flags: transfer complete, write collision and mode fault. Any read of the status register clears all three. A write to the data register while a transfer is running is discarded and counted as a collision. A slave-select driven low by another device while this block is master is a mode fault: the block falls back to slave mode, releases SCLK and MOSI, and abandons the byte. An optional interrupt follows the transfer-complete flag.

Top module: `spi_sc_top`

## Requirements
- R1: After reset the status register reads 0x00, the control register reads 0x00 (slave, interrupt disabled), the receive buffer reads 0x00, `irq` is 0, and `sclk_oe`, `mosi_oe` and `miso_oe` are 0.
- R2: Register addresses are 0 = data, 1 = status, 2 = control. In the status byte, bit 7 is transfer complete, bit 6 is write collision and bit 4 is mode fault. Bits 5 and 3..0 always read 0. In the control byte, bit 0 selects master mode and bit 1 enables the interrupt.
- R3: A CPU read of the status register clears its three flags on the following clock edge. A flag event in that same cycle wins, and its flag stays set.
- R4: The transfer-complete flag sets once a full byte has been shifted, in both master and slave roles. The receive buffer takes the received byte on the same clock edge.
- R5: `irq` is 1 exactly while the transfer-complete flag and the interrupt enable are both 1, so it drops once a status read clears the flag.
- R6: In master mode a data write starts a transfer. SCLK is driven (`sclk_oe`=1), idles low, has a period of DIV system clocks and gives exactly 8 pulses per byte.
- R7: Data moves MSB first in mode 0. MOSI holds each bit before the rising SCLK edge, MISO is sampled on the rising edge, and the shifter advances on the falling edge.
- R8: A data write during a transfer sets the write-collision flag and is discarded. The byte in flight goes out unchanged and its reply is received normally.
- R9: While master, a low slave-select input is a mode fault. It sets the mode-fault flag, clears the control master bit, drops `sclk_oe` and `mosi_oe`, and aborts the transfer without setting transfer complete.
- R10: In slave mode a data write preloads the shifter without starting anything. While `ss_n_i` is low the block drives `miso_o` (`miso_oe`=1), samples `mosi_i` on rising `sclk_i` and shifts on falling `sclk_i`.
- R11: Reads and writes of address 0 are separate. A read returns the receive buffer, never the byte last written.
- R12: With the interrupt enable at 0, transfer complete still sets but `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (status read side effect) |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, combinational from address |
| irq | output | 1 | Interrupt request, level |
| sclk_o | output | 1 | Serial clock when master |
| sclk_oe | output | 1 | Serial clock output enable |
| sclk_i | input | 1 | Serial clock from external master |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Master data out enable |
| mosi_i | input | 1 | Data in when slave |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data out enable |
| miso_i | input | 1 | Data in when master |
| ss_n_i | input | 1 | Active-low slave-select input |

## Verification
The master path is run with the byte pairs 0xA5/0x3C and 0xFF/0x00. Asymmetric patterns show whether the bit order or the edge on which a bit is sampled is wrong, and all-ones against all-zeros shows whether the transmit and receive paths are crossed. A second write is made in the middle of a byte to confirm that the byte on the wire is unchanged and only the collision flag records it. The slave path is run with a preloaded 0x96 against an incoming 0x5B, and MISO is sampled before each rising edge. A mode fault is forced halfway through a master byte to confirm the abort and the role change.

// File: rtl/spi_sc_pkg.sv
`timescale 1ns/1ps
package spi_sc_pkg;
   typedef enum logic [1:0] {
      ADDR_DATA = 2'd0,
      ADDR_STAT = 2'd1,
      ADDR_CTRL = 2'd2
   } spi_sc_addr_e;

   localparam int ST_DONE  = 7;
   localparam int ST_COLL  = 6;
   localparam int ST_FAULT = 4;
   localparam int CT_MSTR  = 0;
   localparam int CT_IEN   = 1;
   localparam int REG_MIN_W = 8;
endpackage

// File: rtl/spi_sc_sync.sv
`timescale 1ns/1ps
module spi_sc_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 0) begin : g_bad_stages
         $error("spi_sc_sync: STAGES must be non-negative");
      end
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
            end else begin
               stg_q[0] <= d;
               for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
            end
         end
         assign q = stg_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_sc_tick.sv
`timescale 1ns/1ps
module spi_sc_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int HALF = DIV / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

   generate
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("spi_sc_tick: DIV must be even and at least 2");
      end
      if (HALF == 1) begin : g_every
         assign tick = run;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     cnt_q <= '0;
            else if (!run)                  cnt_q <= '0;
            else if (cnt_q == CW'(HALF-1))  cnt_q <= '0;
            else                            cnt_q <= cnt_q + 1'b1;
         end
         assign tick = run && (cnt_q == CW'(HALF-1));

         // R6: half periods are HALF cycles, so two ticks never touch
         p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/spi_sc_engine.sv
`timescale 1ns/1ps
module spi_sc_engine #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              abort,
   input  logic              tick,
   input  logic              miso_i,
   input  logic              s_sclk,
   input  logic              s_mosi,
   input  logic              s_ss_act,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_byte,
   output logic              sclk,
   output logic              sdo
);
   localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

   logic [DATA_W-1:0] sh_q;
   logic [CW-1:0]     cnt_q;
   logic              samp_q, sclk_q, busy_q, done_q, sprev_q;
   logic              s_rise, s_fall;

   assign s_rise = s_sclk && !sprev_q;
   assign s_fall = !s_sclk && sprev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         cnt_q   <= '0;
         samp_q  <= 1'b0;
         sclk_q  <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         sprev_q <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         sprev_q <= s_sclk;
         if (abort) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            cnt_q  <= '0;
         end else if (load) begin
            sh_q   <= load_data;
            cnt_q  <= '0;
            sclk_q <= 1'b0;
            busy_q <= master;
         end else if (master) begin
            if (busy_q && tick) begin
               if (!sclk_q) begin
                  sclk_q <= 1'b1;
                  samp_q <= miso_i;
               end else begin
                  sclk_q <= 1'b0;
                  sh_q   <= {sh_q[DATA_W-2:0], samp_q};
                  if (cnt_q == LAST) begin
                     busy_q <= 1'b0;
                     cnt_q  <= '0;
                     done_q <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
         end else begin
            if (!s_ss_act) begin
               cnt_q <= '0;
            end else if (s_rise) begin
               samp_q <= s_mosi;
            end else if (s_fall) begin
               sh_q <= {sh_q[DATA_W-2:0], samp_q};
               if (cnt_q == LAST) begin
                  cnt_q  <= '0;
                  done_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
      end
   end

   assign busy    = master ? busy_q : s_ss_act;
   assign done    = done_q;
   assign rx_byte = sh_q;
   assign sclk    = sclk_q;
   assign sdo     = sh_q[DATA_W-1];

   // R6: serial clock rests low whenever no master byte is running
   p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !sclk_q);
   // R4: completion is a single-cycle event
   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   // R9: an abort leaves the engine idle
   p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !busy_q && !done_q);
endmodule

// File: rtl/spi_sc_top.sv
`timescale 1ns/1ps
module spi_sc_top
   import spi_sc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV         = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [1:0]        cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              irq,
   output logic              sclk_o,
   output logic              sclk_oe,
   input  logic              sclk_i,
   output logic              mosi_o,
   output logic              mosi_oe,
   input  logic              mosi_i,
   output logic              miso_o,
   output logic              miso_oe,
   input  logic              miso_i,
   input  logic              ss_n_i
);
   generate
      if (DATA_W < REG_MIN_W) begin : g_bad_width
         $error("spi_sc_top: DATA_W must hold the 8-bit status layout");
      end
   endgenerate

   logic [2:0] pin_raw, pin_syn;
   logic       s_sclk, s_mosi, s_ss_act;

   assign pin_raw = {ss_n_i, mosi_i, sclk_i};

   spi_sc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_raw),
      .q    (pin_syn)
   );

   assign s_sclk   = pin_syn[0];
   assign s_mosi   = pin_syn[1];
   assign s_ss_act = !pin_syn[2];

   logic              master_q, ien_q, done_f_q, coll_f_q, fault_f_q;
   logic [DATA_W-1:0] rxbuf_q;
   logic              data_wr, ctrl_wr, stat_rd;
   logic              mode_fault, eng_load, eng_coll;
   logic              eng_busy, eng_done, eng_tick, eng_sclk, eng_sdo;
   logic [DATA_W-1:0] eng_rx;

   assign data_wr    = cpu_wr && (cpu_addr == ADDR_DATA);
   assign ctrl_wr    = cpu_wr && (cpu_addr == ADDR_CTRL);
   assign stat_rd    = cpu_rd && (cpu_addr == ADDR_STAT);
   assign mode_fault = master_q && s_ss_act;
   assign eng_coll   = data_wr && eng_busy;
   assign eng_load   = data_wr && !eng_busy && !mode_fault;

   spi_sc_tick #(.DIV(DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (eng_busy && master_q),
      .tick (eng_tick)
   );

   spi_sc_engine #(.DATA_W(DATA_W)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .master   (master_q),
      .load     (eng_load),
      .load_data(cpu_wdata),
      .abort    (mode_fault),
      .tick     (eng_tick),
      .miso_i   (miso_i),
      .s_sclk   (s_sclk),
      .s_mosi   (s_mosi),
      .s_ss_act (s_ss_act),
      .busy     (eng_busy),
      .done     (eng_done),
      .rx_byte  (eng_rx),
      .sclk     (eng_sclk),
      .sdo      (eng_sdo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         master_q  <= 1'b0;
         ien_q     <= 1'b0;
         done_f_q  <= 1'b0;
         coll_f_q  <= 1'b0;
         fault_f_q <= 1'b0;
         rxbuf_q   <= '0;
      end else begin
         if (mode_fault)   master_q <= 1'b0;
         else if (ctrl_wr) master_q <= cpu_wdata[CT_MSTR];
         if (ctrl_wr)      ien_q    <= cpu_wdata[CT_IEN];
         if (eng_done)     rxbuf_q  <= eng_rx;
         done_f_q  <= eng_done   || (done_f_q  && !stat_rd);
         coll_f_q  <= eng_coll   || (coll_f_q  && !stat_rd);
         fault_f_q <= mode_fault || (fault_f_q && !stat_rd);
      end
   end

   logic [DATA_W-1:0] stat_v, ctrl_v;
   always_comb begin
      stat_v           = '0;
      stat_v[ST_DONE]  = done_f_q;
      stat_v[ST_COLL]  = coll_f_q;
      stat_v[ST_FAULT] = fault_f_q;
      ctrl_v           = '0;
      ctrl_v[CT_MSTR]  = master_q;
      ctrl_v[CT_IEN]   = ien_q;
   end

   always_comb begin
      unique case (cpu_addr)
         ADDR_DATA: cpu_rdata = rxbuf_q;
         ADDR_STAT: cpu_rdata = stat_v;
         ADDR_CTRL: cpu_rdata = ctrl_v;
         default:   cpu_rdata = '0;
      endcase
   end

   assign irq     = done_f_q && ien_q;
   assign sclk_o  = eng_sclk;
   assign sclk_oe = master_q;
   assign mosi_o  = eng_sdo;
   assign mosi_oe = master_q;
   assign miso_o  = eng_sdo;
   assign miso_oe = !master_q && s_ss_act;

   // R4: the completion flag only rises after the engine finished a byte
   p_done_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_f_q) |-> $past(eng_done));
   // R3: a status read with no new completion clears the flag
   p_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !eng_done) |=> !done_f_q);
   // R5: the interrupt falls with the flag on a status read
   p_irq_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !eng_done) |=> !irq);
   // R8: a collision is only recorded while the engine was busy
   p_coll_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(coll_f_q) |-> $past(eng_busy));
   // R9: a fault leaves the block as slave
   p_fault_slave_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_f_q) |-> !master_q && !sclk_oe);
   // R10: slave never drives MISO together with master outputs
   p_one_driver_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(miso_oe && mosi_oe));
endmodule

// File: tb/spi_sc_top_tb_top.sv
`timescale 1ns/1ps
module spi_sc_top_tb_top;
   localparam int DW  = 8;
   localparam int DIV = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_wr = 1'b0, cpu_rd = 1'b0;
   logic [1:0]    cpu_addr = 2'd0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [DW-1:0] cpu_rdata;
   logic          irq, sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe;
   logic          sclk_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
   logic          miso_i;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   spi_sc_top #(.DATA_W(DW), .DIV(DIV), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
      .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sclk_i(sclk_i),
      .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
      .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i),
      .ss_n_i(ss_n_i)
   );

   // external slave model: MSB first, next bit after each falling SCLK
   logic [7:0] mosi_cap = '0;
   int         fall_cnt = 0;
   int         base_cnt = 0;
   logic [7:0] slv_byte = '0;

   always @(posedge sclk_o) mosi_cap <= {mosi_cap[6:0], mosi_o};
   always @(negedge sclk_o) fall_cnt <= fall_cnt + 1;

   always_comb begin
      int idx;
      idx = fall_cnt - base_cnt;
      if (idx >= 0 && idx < 8) miso_i = slv_byte[3'(7 - idx)];
      else                     miso_i = 1'b0;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      cpu_rd = 1'b1; cpu_addr = a;
      #1 d = cpu_rdata;
      @(negedge clk);
      cpu_rd = 1'b0;
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [7:0] v;
      cpu_read(2'd1, v); chk("R1 status", v, 8'h00);
      cpu_read(2'd2, v); chk("R1 control", v, 8'h00);
      cpu_read(2'd0, v); chk("R1 rxbuf", v, 8'h00);
      chk("R1 irq", irq, 0);
      chk("R1 enables", {sclk_oe, mosi_oe, miso_oe}, 3'b000);
   endtask

   task automatic t_master_basic;
      logic [7:0] v;
      cpu_write(2'd2, 8'h03);
      chk("R6 sclk_oe", sclk_oe, 1);
      chk("R6 sclk idle", sclk_o, 0);
      base_cnt = fall_cnt; slv_byte = 8'h3C;
      cpu_write(2'd0, 8'hA5);
      wait_clk(2);
      chk("R4 no early done", irq, 0);
      wait_clk(40);
      chk("R7 mosi bits", mosi_cap, 8'hA5);
      chk("R6 pulse count", fall_cnt - base_cnt, 8);
      chk("R5 irq set", irq, 1);
      cpu_read(2'd1, v); chk("R2 status done", v, 8'h80);
      chk("R5 irq after read", irq, 0);
      cpu_read(2'd1, v); chk("R3 cleared", v, 8'h00);
      cpu_read(2'd0, v); chk("R11 rxbuf not tx", v, 8'h3C);
   endtask

   task automatic t_collision;
      logic [7:0] v;
      base_cnt = fall_cnt; slv_byte = 8'h69;
      cpu_write(2'd0, 8'hC3);
      wait_clk(6);
      cpu_write(2'd0, 8'h11);
      wait_clk(40);
      chk("R8 byte unchanged", mosi_cap, 8'hC3);
      cpu_read(2'd1, v); chk("R8 status", v, 8'hC0);
      cpu_read(2'd0, v); chk("R8 reply", v, 8'h69);
      chk("R8 no extra pulses", fall_cnt - base_cnt, 8);
   endtask

   task automatic t_no_irq;
      logic [7:0] v;
      cpu_write(2'd2, 8'h01);
      base_cnt = fall_cnt; slv_byte = 8'h00;
      cpu_write(2'd0, 8'hFF);
      wait_clk(42);
      chk("R12 irq off", irq, 0);
      chk("R7 all ones", mosi_cap, 8'hFF);
      cpu_read(2'd1, v); chk("R12 flag still set", v, 8'h80);
      cpu_read(2'd0, v); chk("R4 rx zeros", v, 8'h00);
   endtask

   task automatic t_mode_fault;
      logic [7:0] v;
      cpu_write(2'd2, 8'h03);
      base_cnt = fall_cnt; slv_byte = 8'hAA;
      cpu_write(2'd0, 8'h5A);
      wait_clk(10);
      ss_n_i = 1'b0;
      wait_clk(8);
      chk("R9 sclk released", sclk_oe, 0);
      chk("R9 mosi released", mosi_oe, 0);
      cpu_read(2'd2, v); chk("R9 master cleared", v, 8'h02);
      wait_clk(30);
      chk("R9 no irq", irq, 0);
      cpu_read(2'd1, v); chk("R9 status fault only", v, 8'h10);
      cpu_read(2'd0, v); chk("R9 rx kept", v, 8'h00);
      ss_n_i = 1'b1;
      wait_clk(6);
   endtask

   task automatic t_slave;
      logic [7:0] v;
      logic [7:0] miso_cap;
      logic [7:0] din;
      din = 8'h5B;
      miso_cap = '0;
      cpu_write(2'd2, 8'h02);
      cpu_write(2'd0, 8'h96);
      wait_clk(10);
      chk("R10 no start", miso_oe, 0);
      cpu_read(2'd1, v); chk("R10 no done", v, 8'h00);
      ss_n_i = 1'b0;
      wait_clk(6);
      chk("R10 miso_oe", miso_oe, 1);
      for (int i = 7; i >= 0; i--) begin
         mosi_i = din[i];
         wait_clk(10);
         miso_cap = {miso_cap[6:0], miso_o};
         sclk_i = 1'b1;
         wait_clk(10);
         sclk_i = 1'b0;
         wait_clk(10);
      end
      ss_n_i = 1'b1;
      wait_clk(10);
      chk("R10 miso bits", miso_cap, 8'h96);
      chk("R5 slave irq", irq, 1);
      cpu_read(2'd0, v); chk("R4 slave rx", v, 8'h5B);
      cpu_read(2'd1, v); chk("R4 slave status", v, 8'h80);
   endtask

   initial begin
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(2);
      t_reset();
      t_master_basic();
      t_collision();
      t_no_irq();
      t_mode_fault();
      t_slave();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule